// File: doc/BRIEF.md
# Viterbi Survivor Traceback with Three Rotating Banks

This block is the back end of a 64-state, constraint-length-7 Viterbi decoder. For every accepted symbol it takes the 64-bit survivor decision word from the path metric unit, plus the index of the currently best state. It stores each word in one of three small banks. It then recovers the decoded bit stream by walking backwards through the stored decisions.

Symbols are grouped into blocks of 36. While a block is being written, the block before it is traced back from the best state. That traceback finds the state where the older block ends. The older block is decoded from that state, and each word it frees is overwritten by the incoming block in the same cycle. The address order flips at every block, so one address counter serves the write, both traceback walks and the reorder buffer. The decoded bits of a block come out newest first. A 36-entry stack turns them back into time order, and the output delivers one bit per accepted symbol once the pipeline is full.

Top module: `survivor_traceback`

## Requirements
- R1: After reset `bit_valid` is low, and it stays low until 144 symbols (four blocks of 36) have been accepted.
- R2: From the 145th accepted symbol on, each accepted symbol raises `bit_valid` for exactly one cycle, in the cycle after it was accepted. `bit_valid` is never high in a cycle that does not follow an accepted symbol.
- R3: The bit delivered after accepted symbol n (n ≥ 144) is the decoded bit of symbol n − 144, so the output stream keeps the original symbol order.
- R4: A traceback step from state c (6 bits) moves to the predecessor {w[c], c[5:1]}, where w is the stored survivor word of that symbol and bit i of `surv_word` is the decision for state i.
- R5: The decoded bit of a symbol is bit 5 (the MSB) of the state that the traced path holds at that symbol.
- R6: `best_state` is used only on the last symbol of each block, i.e. on accepted symbols whose index counted from reset is 35, 71, 107 and so on. Its value on every other symbol has no effect on the output.
- R7: The traceback of the newest complete block, started from the sampled best state, gives the start state for decoding the block before it. If all survivor paths merge inside the newest block, a wrong `best_state` still yields the correct bits.
- R8: Cycles with `sym_valid` low change no stored state: the banks, the bank roles and the address order stay as they are. The decoded stream is the same whether or not idle cycles are inserted between symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A new symbol's survivor word is presented |
| surv_word | input | 64 | One decision bit per trellis state; bit i belongs to state i |
| best_state | input | 6 | Best state at the current symbol; sampled at block ends only |
| bit_valid | output | 1 | One-cycle strobe marking a decoded bit |
| bit_out | output | 1 | Decoded bit, in original symbol order |

## Verification
The bench drives a known trellis trajectory, with random decisions on every state off that path. It aims at these cases:
- The first 144 symbols, where a design with the wrong fill count strobes stale data.
- The block boundaries, where a wrong flip of the address order or a wrong bank rotation reverses or scrambles whole blocks.
- Random `best_state` values on every non-final symbol, which a design sampling at the wrong time turns into wrong bits.
- Blocks with merged paths and wrong start states, which catch a decoder that takes its start state from the wrong traceback.
- Random idle gaps, which expose any state that advances without an accepted symbol.

// File: rtl/survivor_traceback_pkg.sv
package survivor_traceback_pkg;

    localparam int unsigned NUM_BANKS   = 3;
    localparam int unsigned FILL_BLOCKS = 4;

    typedef logic [1:0] bank_idx_t;

    function automatic bank_idx_t bank_next(input bank_idx_t b);
        return (b == bank_idx_t'(NUM_BANKS - 1)) ? '0 : b + 2'd1;
    endfunction

    function automatic bank_idx_t bank_prev(input bank_idx_t b);
        return (b == '0) ? bank_idx_t'(NUM_BANKS - 1) : b - 2'd1;
    endfunction

endpackage

// File: rtl/survivor_bank_array.sv
module survivor_bank_array
    import survivor_traceback_pkg::*;
#(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned DEPTH  = 36,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  bank_idx_t         wr_bank,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    input  bank_idx_t         rd_bank_a,
    output logic [WORD_W-1:0] rd_data_a,
    input  bank_idx_t         rd_bank_b,
    output logic [WORD_W-1:0] rd_data_b
);

    logic [WORD_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] word_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == bank_idx_t'(b))) begin
                word_q[addr] <= wr_data;
            end
        end

        // asynchronous read: returns the old word in a write cycle
        assign bank_rd[b] = word_q[addr];
    end

    assign rd_data_a = bank_rd[rd_bank_a];
    assign rd_data_b = bank_rd[rd_bank_b];

endmodule

// File: rtl/survivor_trace_step.sv
module survivor_trace_step #(
    parameter int unsigned STATE_W = 6,
    localparam int unsigned NS     = 1 << STATE_W
) (
    input  logic [NS-1:0]      word,
    input  logic [STATE_W-1:0] cur_state,
    output logic [STATE_W-1:0] prev_state
);

    assign prev_state = {word[cur_state], cur_state[STATE_W-1:1]};

endmodule

// File: rtl/survivor_reorder.sv
module survivor_reorder #(
    parameter int unsigned DEPTH = 36,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic          push_bit,
    output logic          pop_bit
);

    logic [DEPTH-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (en) begin
            slot_q[addr] <= push_bit;
        end
    end

    assign pop_bit = slot_q[addr];

endmodule

// File: rtl/survivor_traceback.sv
module survivor_traceback
    import survivor_traceback_pkg::*;
#(
    parameter int unsigned STATE_W = 6,
    parameter int unsigned DEPTH   = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sym_valid,
    input  logic [(1 << STATE_W)-1:0]   surv_word,
    input  logic [STATE_W-1:0]          best_state,
    output logic                        bit_valid,
    output logic                        bit_out
);

    localparam int unsigned NS = 1 << STATE_W;
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned FW = $clog2(FILL_BLOCKS + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef logic [STATE_W-1:0] state_t;

    typedef struct packed {
        logic [AW-1:0] step;
        logic          fwd;
        bank_idx_t     wbank;
        logic [FW-1:0] fill;
        state_t        tb;
        state_t        dc;
        logic          vld;
        logic          obit;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [AW-1:0] rd_addr;
    bank_idx_t     wr_bank;
    bank_idx_t     tb_bank;
    logic [NS-1:0] tb_word;
    logic [NS-1:0] dc_word;
    state_t        tb_prev;
    state_t        dc_prev;
    logic          pop_bit;

    // the order flips each block, so one counter addresses every access
    assign rd_addr = cur_q.fwd ? cur_q.step : (LAST - cur_q.step);
    assign wr_bank = cur_q.wbank;
    assign tb_bank = bank_prev(cur_q.wbank);

    survivor_bank_array #(.WORD_W(NS), .DEPTH(DEPTH)) banks_i (
        .clk       (clk),
        .wr_en     (sym_valid),
        .wr_bank   (wr_bank),
        .addr      (rd_addr),
        .wr_data   (surv_word),
        .rd_bank_a (tb_bank),
        .rd_data_a (tb_word),
        .rd_bank_b (wr_bank),
        .rd_data_b (dc_word)
    );

    survivor_trace_step #(.STATE_W(STATE_W)) tb_step_i (
        .word       (tb_word),
        .cur_state  (cur_q.tb),
        .prev_state (tb_prev)
    );

    survivor_trace_step #(.STATE_W(STATE_W)) dc_step_i (
        .word       (dc_word),
        .cur_state  (cur_q.dc),
        .prev_state (dc_prev)
    );

    survivor_reorder #(.DEPTH(DEPTH)) lifo_i (
        .clk      (clk),
        .en       (sym_valid),
        .addr     (rd_addr),
        .push_bit (cur_q.dc[STATE_W-1]),
        .pop_bit  (pop_bit)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (sym_valid) begin
            nxt_d.vld  = (cur_q.fill == FW'(FILL_BLOCKS));
            nxt_d.obit = pop_bit;
            nxt_d.tb   = tb_prev;
            nxt_d.dc   = dc_prev;
            if (cur_q.step == LAST) begin
                nxt_d.step  = '0;
                nxt_d.fwd   = ~cur_q.fwd;
                nxt_d.wbank = bank_next(cur_q.wbank);
                nxt_d.tb    = best_state;
                nxt_d.dc    = tb_prev;
                if (cur_q.fill != FW'(FILL_BLOCKS)) begin
                    nxt_d.fill = cur_q.fill + 1'b1;
                end
            end else begin
                nxt_d.step = cur_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{step: '0, fwd: 1'b1, wbank: '0, fill: '0,
                       tb: '0, dc: '0, vld: 1'b0, obit: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bit_valid = cur_q.vld;
    assign bit_out   = cur_q.obit;

endmodule

// File: rtl/survivor_traceback_chk.sv
module survivor_traceback_chk
    import survivor_traceback_pkg::*;
#(
    parameter int unsigned DEPTH     = 36,
    parameter int unsigned FILL_SYMS = 144,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CW       = $clog2(FILL_SYMS + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sym_valid,
    input logic          bit_valid,
    input bank_idx_t     wr_bank,
    input logic [AW-1:0] rd_addr
);

    logic [CW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (sym_valid && (acc_q <= CW'(FILL_SYMS))) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    assert_silent_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (acc_q > CW'(FILL_SYMS)));

    assert_strobe_needs_symbol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(sym_valid));

    assert_steady_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (acc_q >= CW'(FILL_SYMS))) |=> bit_valid);

    assert_addr_in_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr < AW'(DEPTH));

    assert_bank_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank < bank_idx_t'(NUM_BANKS));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> ($stable(wr_bank) && $stable(rd_addr)));

    assert_rotate_on_symbol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bank != $past(wr_bank)) |-> $past(sym_valid));

endmodule

bind survivor_traceback survivor_traceback_chk #(
    .DEPTH     (DEPTH),
    .FILL_SYMS (FILL_BLOCKS * DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .bit_valid (bit_valid),
    .wr_bank   (wr_bank),
    .rd_addr   (rd_addr)
);

// File: tb/survivor_traceback_tb.sv
module survivor_traceback_tb_top;

    localparam int DEPTH  = 36;
    localparam int FILL   = 4 * DEPTH;
    localparam int BLOCKS = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [63:0] surv_word = '0;
    logic [5:0]  best_state = '0;
    logic        bit_valid;
    logic        bit_out;

    always #5 clk = ~clk;

    survivor_traceback dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .surv_word  (surv_word),
        .best_state (best_state),
        .bit_valid  (bit_valid),
        .bit_out    (bit_out)
    );

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    int accepted = 0;
    bit last_acc = 1'b0;
    int popped = 0;
    bit mon_on = 1'b0;

    function automatic string tag_of(input int sym);
        int blk;
        blk = sym / DEPTH;
        if (blk < 6)  return "R3/R4/R5";
        if (blk < 10) return "R6/R8";
        return "R7";
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        last_acc <= rst_n && sym_valid;
        if (rst_n && sym_valid) accepted <= accepted + 1;
    end

    // monitor: strobe timing and scoreboard comparison
    always @(negedge clk) begin
        if (mon_on) begin
            bit ev;
            bit e;
            ev = last_acc && (accepted > FILL);
            checks++;
            if (bit_valid !== ev) begin
                fails++;
                $display("FAIL %s: bit_valid=%0b expected %0b after %0d symbols",
                         (accepted <= FILL) ? "R1" : "R2", bit_valid, ev, accepted);
            end
            if (bit_valid && ev) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3: output bit %0b with empty scoreboard, expected none", bit_out);
                end else begin
                    e = exp_q.pop_front();
                    if (bit_out !== e) begin
                        fails++;
                        $display("FAIL %s: symbol %0d bit=%0b expected %0b",
                                 tag_of(popped), popped, bit_out, e);
                    end
                    popped++;
                end
            end
        end
    end

    // driver: walks a known trajectory; the decoded bit is the state MSB
    task automatic drive_stream();
        logic [5:0] st;
        st = '0;
        for (int blk = 0; blk < BLOCKS; blk++) begin
            for (int s = 0; s < DEPTH; s++) begin
                logic [5:0]  nst;
                logic [63:0] w;
                bit phase_b;
                bit phase_c;
                phase_b = (blk >= 6) && (blk < 10);
                phase_c = (blk >= 10) && (blk < 14);
                if (phase_b) begin
                    // R8: idle cycles with garbage on the data inputs
                    for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                        @(negedge clk);
                        sym_valid  = 1'b0;
                        surv_word  = {$urandom, $urandom};
                        best_state = 6'($urandom);
                    end
                end
                nst = {st[4:0], 1'($urandom)};
                if (phase_c) begin
                    w = {64{st[5]}};                // R7: every path merges
                end else begin
                    w = {$urandom, $urandom};
                    w[nst] = st[5];                 // R4: decision of the true path
                end
                @(negedge clk);
                sym_valid = 1'b1;
                surv_word = w;
                if (phase_c) best_state = 6'($urandom);                // R7
                else if (s == DEPTH - 1) best_state = nst;
                else if (phase_b) best_state = 6'($urandom);           // R6
                else best_state = nst;
                exp_q.push_back(nst[5]);            // R5
                st = nst;
            end
        end
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (bit_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: bit_valid=%0b after reset, expected 0", bit_valid);
        end
        mon_on = 1'b1;
        drive_stream();
        repeat (6) @(negedge clk);
        mon_on = 1'b0;
        checks++;
        if (popped != BLOCKS * DEPTH - FILL) begin
            fails++;
            $display("FAIL R2: %0d bits delivered, expected %0d", popped, BLOCKS * DEPTH - FILL);
        end
        checks++;
        if (exp_q.size() != FILL) begin
            fails++;
            $display("FAIL R3: %0d bits still pending, expected %0d", exp_q.size(), FILL);
        end
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2: watchdog expired, got %0d bits, expected %0d", popped, BLOCKS * DEPTH - FILL);
        summary();
        $finish;
    end

endmodule